// File: doc/BRIEF.md
# Bit-Serial Partitioned-Table FIR Filter

This block is a multiplierless FIR filter. It computes the exact dot product of the most recent `NTAP` input samples with a set of constant coefficients. Each accepted sample enters a tap history. All taps are then copied into per-tap shift registers, which release one bit per clock with the least significant bit first. In each cycle the current bit of every tap forms an address. The taps are divided into groups of possibly unequal size, and each group owns a small precomputed table. That table holds every signed sum of the group's coefficients, and the address picks one of them. The group outputs are added together. A shift-accumulator then combines the `XW` bit-slice sums into the result, subtracting the slice that belongs to the sign bit.

The table contents are built during elaboration from the `COEF` parameter. The grouping comes from `GSZ`, whose entries must add up to `NTAP`. The default configuration is 15 taps with 10-bit coefficients, 8-bit signed samples and groups of 6, 6 and 3 taps.

Samples arrive over a valid/ready handshake. A transfer happens on a rising edge where `in_valid` and `in_ready` are both high. After a transfer, `in_ready` stays low while the filter works through the sample's bits, so the source has to hold its sample until it sees `in_ready`. There is no back-pressure on the output side. `out_valid` is a single-cycle strobe, and `out_data` keeps its value until the next strobe.

Top module: `dafir_fir`

## Requirements
- R1: Reset state. During and after reset, `out_valid` is 0, `in_ready` is 1 and `out_data` is 0. The tap history is cleared, so positions that have not yet received a sample count as zero.
- R2: Input handshake. A sample is consumed only on an edge where `in_valid` and `in_ready` are both high. `in_ready` is low from the edge after a transfer until the result appears. Cycles with `in_valid` low leave the tap history unchanged.
- R3: Output timing. `out_valid` rises exactly `XW` (8) clock edges after the transfer edge and stays high for one cycle only.
- R4: Result value. `out_data` is the two's-complement value of sum over k of `COEF[k]`·x[t−k], `RW` = `XW`+`CW`+ceil(log2 `NTAP`) = 22 bits wide. x[t] is the newest sample and x[t−k] is the one accepted k transfers earlier.
- R5: Range. All-maximum (+127) and all-minimum (−128) sample streams give the exact result with no wrap-around.
- R6: Signed samples. The slice for sample bit `XW`−1 carries weight −2^(`XW`−1), so negative samples contribute negatively.
- R7: Back-to-back flow. `in_ready` is high in the cycle where `out_valid` is high, so the next sample can be taken on the edge that ends the strobe.
- R8: Partitioning. The tap grouping does not change the result. The impulse response reproduces every coefficient, including those in the smaller group.
- R9: Result hold. `out_data` changes only at the edge that raises `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Filter can take a sample |
| in_data | input | XW | Signed input sample |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | RW | Signed filter result, held between strobes |

## Verification
On every cycle, the bound checker enforces the handshake rules:
- `in_ready` drops after a transfer and stays low while the bits are processed.
- The strobe comes exactly eight edges after the transfer and lasts one cycle.
- `in_ready` is high during the strobe.
- `out_data` is stable when there is no strobe.

The arithmetic can only be shown by the bench's scenarios, which compare each result against a direct multiply-accumulate over the same history:
- an impulse that walks through every group;
- saturated positive and negative streams;
- alternating signs;
- pseudo-random samples with idle gaps.

// File: rtl/dafir_pkg.sv
package dafir_pkg;

  // ceiling of log2, with clg2(1) == 0
  function automatic int unsigned clg2(input int unsigned v);
    int unsigned r;
    r = 0;
    while ((64'd1 << r) < 64'(v)) r = r + 1;
    return r;
  endfunction

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;

endpackage

// File: rtl/dafir_tapline.sv
module dafir_tapline #(
  parameter int unsigned NTAP = 15,
  parameter int unsigned XW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            shift,
  input  logic [XW-1:0]   din,
  output logic [NTAP-1:0] lsb
);

  // history holds taps 0..NTAP-2; the oldest tap only lives in its shifter
  logic [XW-1:0] hist [NTAP-1];
  logic [XW-1:0] shr  [NTAP];

  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          hist[0] <= '0;
          shr[0]  <= '0;
        end else if (load) begin
          hist[0] <= din;
          shr[0]  <= din;
        end else if (shift) begin
          shr[0]  <= shr[0] >> 1;
        end
      end
    end else begin : g_body
      if (i < NTAP - 1) begin : g_keep
        always_ff @(posedge clk) begin
          if (!rst_n)    hist[i] <= '0;
          else if (load) hist[i] <= hist[i-1];
        end
      end
      always_ff @(posedge clk) begin
        if (!rst_n)       shr[i] <= '0;
        else if (load)    shr[i] <= hist[i-1];
        else if (shift)   shr[i] <= shr[i] >> 1;
      end
    end
    assign lsb[i] = shr[i][0];
  end

endmodule

// File: rtl/dafir_grp_table.sv
module dafir_grp_table #(
  parameter int unsigned NTAP = 15,
  parameter int unsigned CW   = 10,
  parameter int unsigned K    = 6,
  parameter int unsigned OFS  = 0,
  parameter int          COEF [NTAP] = '{default: 0},
  localparam int unsigned TW    = dafir_pkg::clg2(K) + CW,
  localparam int unsigned DEPTH = 1 << K
) (
  input  logic        [K-1:0]  addr,
  output logic signed [TW-1:0] val
);

  // entry a = sum of this group's coefficients whose address bit is set
  function automatic logic signed [TW-1:0] entry_f(input int unsigned a);
    int s;
    s = 0;
    for (int j = 0; j < int'(K); j++) begin
      if (a[j]) s = s + COEF[OFS + j];
    end
    return TW'(s);
  endfunction

  logic signed [TW-1:0] tbl [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_ent
    assign tbl[a] = entry_f(a);
  end

  assign val = tbl[addr];

endmodule

// File: rtl/dafir_slice_acc.sv
module dafir_slice_acc #(
  parameter int unsigned NGRP = 3,
  parameter int unsigned XW   = 8,
  parameter int unsigned SW   = 14,
  localparam int unsigned RW  = SW + XW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 step,
  input  logic                 last,
  input  logic signed [SW-1:0] gval [NGRP],
  output logic signed [RW-1:0] res
);

  logic signed [SW-1:0] slice;
  logic signed [SW-1:0] hi;
  logic        [XW-2:0] lo;
  logic signed [SW:0]   sum;

  // adder stage over the group table outputs
  always_comb begin
    slice = '0;
    for (int g = 0; g < int'(NGRP); g++) slice = slice + gval[g];
  end

  // sign slice is subtracted; sum fits SW+1 bits because |hi| < max|slice|
  always_comb begin
    if (last) sum = (SW+1)'(hi) - (SW+1)'(slice);
    else      sum = (SW+1)'(hi) + (SW+1)'(slice);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi  <= '0;
      lo  <= '0;
      res <= '0;
    end else if (start) begin
      hi  <= '0;
      lo  <= '0;
    end else if (step) begin
      hi <= sum[SW:1];
      lo <= {sum[0], lo[XW-2:1]};
      if (last) res <= {sum, lo};
    end
  end

endmodule

// File: rtl/dafir_fir.sv
module dafir_fir #(
  parameter int unsigned NTAP = 15,
  parameter int unsigned XW   = 8,
  parameter int unsigned CW   = 10,
  parameter int          COEF [NTAP] = '{23, -53, -108, -79, 55, 257, 438, 511,
                                         438, 257, 55, -79, -108, -53, 23},
  parameter int unsigned NGRP = 3,
  parameter int unsigned GSZ  [NGRP] = '{6, 6, 3},
  localparam int unsigned SW   = CW + dafir_pkg::clg2(NTAP),
  localparam int unsigned RW   = XW + SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [XW-1:0] in_data,
  output logic          out_valid,
  output logic [RW-1:0] out_data
);
  import dafir_pkg::*;

  localparam int unsigned CNTW = (dafir_pkg::clg2(XW) < 1) ? 1 : dafir_pkg::clg2(XW);

  function automatic int unsigned grp_ofs(input int unsigned g);
    int unsigned s;
    s = 0;
    for (int unsigned i = 0; i < g; i++) s = s + GSZ[i];
    return s;
  endfunction

  run_state_e      state;
  logic [CNTW-1:0] cnt;
  logic            accept;
  logic            step;
  logic            last;
  logic [NTAP-1:0] tap_bits;
  logic signed [SW-1:0] gval [NGRP];
  logic signed [RW-1:0] res;

  assign in_ready = (state == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign step     = (state == ST_RUN);
  assign last     = step && (cnt == CNTW'(XW - 1));

  // sequencing: one bit slice per cycle while running
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (accept) begin
        state <= ST_RUN;
        cnt   <= '0;
      end else if (step) begin
        cnt <= cnt + 1'b1;
        if (last) begin
          state     <= ST_IDLE;
          out_valid <= 1'b1;
        end
      end
    end
  end

  dafir_tapline #(.NTAP(NTAP), .XW(XW)) u_taps (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .shift (step),
    .din   (in_data),
    .lsb   (tap_bits)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int unsigned K   = GSZ[g];
    localparam int unsigned OFS = grp_ofs(g);
    localparam int unsigned TW  = dafir_pkg::clg2(K) + CW;
    logic signed [TW-1:0] tv;

    dafir_grp_table #(
      .NTAP (NTAP),
      .CW   (CW),
      .K    (K),
      .OFS  (OFS),
      .COEF (COEF)
    ) u_tbl (
      .addr (tap_bits[OFS +: K]),
      .val  (tv)
    );

    assign gval[g] = SW'(tv);
  end

  dafir_slice_acc #(.NGRP(NGRP), .XW(XW), .SW(SW)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .step  (step),
    .last  (last),
    .gval  (gval),
    .res   (res)
  );

  assign out_data = res;

endmodule

// File: rtl/dafir_fir_chk.sv
module dafir_fir_chk #(
  parameter int unsigned XW = 8,
  parameter int unsigned RW = 22
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic [RW-1:0] out_data
);

  localparam int unsigned LW = $clog2(XW + 2) + 1;
  logic [LW-1:0] lat;

  // edges since last transfer: 1 after the transfer edge, XW+1 at the strobe
  always_ff @(posedge clk) begin
    if (!rst_n)                       lat <= '0;
    else if (in_valid && in_ready)    lat <= LW'(1);
    else if (lat != '0 && lat <= LW'(XW)) lat <= lat + 1'b1;
    else                              lat <= '0;
  end

  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lat != '0 && lat <= LW'(XW)) |-> !in_ready);

  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (lat == LW'(XW + 1)));

  p_strobe_due_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lat == LW'(XW + 1)) |-> out_valid);

  p_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_ready_at_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

endmodule

bind dafir_fir dafir_fir_chk #(.XW(XW), .RW(RW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/sim_dafir_fir.sv
`timescale 1ns/1ps
module sim_dafir_fir;

  localparam int NT = 15;
  localparam int XW = 8;
  localparam int RW = 22;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [XW-1:0] in_data = '0;
  logic          in_ready;
  logic          out_valid;
  logic [RW-1:0] out_data;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int cof [NT] = '{23, -53, -108, -79, 55, 257, 438, 511, 438, 257, 55, -79, -108, -53, 23};
  int hist [NT];
  int exp_q [$];
  string tag_q [$];
  int acc_q [$];
  logic [RW-1:0] last_out = '0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dafir_fir u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // driver: model the history, push expected, complete one transfer (R2)
  task automatic send(input int x, input string req);
    int s;
    while (!in_ready) @(negedge clk);
    for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
    s = 0;
    for (int k = 0; k < NT; k++) s += cof[k] * hist[k];
    exp_q.push_back(s);
    tag_q.push_back(req);
    in_valid = 1'b1;
    in_data  = XW'(x);
    @(negedge clk);
    acc_q.push_back(cyc);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: scoreboard compare, latency, ready-at-done, hold
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        int e;
        int a;
        string t;
        if (exp_q.size() == 0) begin
          check(0, "R3 unexpected strobe", 1, 0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          a = acc_q.pop_front();
          check(int'($signed(out_data)) == e, t, int'($signed(out_data)), e);
          check(cyc - a == XW, "R3 latency", cyc - a, XW);
          check(in_ready == 1'b1, "R7 ready during strobe", int'(in_ready), 1);
        end
        last_out = out_data;
      end else begin
        check(out_data == last_out, "R9 hold", int'($signed(out_data)), int'($signed(last_out)));
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    int lf;
    for (int k = 0; k < NT; k++) hist[k] = 0;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(in_ready == 1'b1, "R1 ready in reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
    check(out_data == '0, "R1 data after reset", int'(out_data), 0);
    // R8 impulse walks every coefficient across all groups (first sample also checks R1 history)
    send(127, "R8 impulse");
    for (int i = 0; i < NT; i++) send(0, "R8 impulse");
    // R5/R6 saturated streams
    for (int i = 0; i < 18; i++) send(-128, "R5 R6 all minimum");
    for (int i = 0; i < 18; i++) send(127, "R5 all maximum");
    // R6 alternating signs
    for (int i = 0; i < 16; i++) send((i % 2) ? -128 : 127, "R6 alternating");
    for (int i = 0; i < 16; i++) send((i % 3 == 0) ? -1 : 1, "R6 small signed");
    // R4 pseudo-random, R2 idle gaps leave history alone
    lf = 32'h1d2c;
    for (int i = 0; i < 60; i++) begin
      lf = (lf >> 1) ^ ((lf & 1) ? 32'hb400 : 0);
      send((lf & 255) - 128, "R4 R2 random with gaps");
      if ((lf & 7) == 3) idle((lf >> 4) & 15);
    end
    // R7 back-to-back with no gaps
    for (int i = 0; i < 8; i++) send(i * 31 - 100, "R7 back-to-back");
    idle(3 * XW);
    check(exp_q.size() == 0, "R3 all results seen", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

endmodule